// File: doc/BRIEF.md
# Power Mode Sequencer

This block steps a lighting and boost-converter chip through its operating modes. Two sources can force the reset mode: the external active-low reset pin and the power-on-reset flag. Once both are released, the chip rests in standby until software sets the standby-release bit. It then powers up its internal blocks and waits a fixed oscillator-settle time. It also waits until the reference reports that it is ready. After that it either runs a timed boost soft-start with the LEDs held off, or goes straight to normal operation, depending on the boost-enable bit.

In normal mode, setting boost-enable again (a rising edge) starts a fresh soft-start. Clearing boost-enable turns the boost off, and the chip stays in normal mode. A thermal-shutdown flag sends the sequencer back to the startup phase from any powered mode. It holds the sequencer there until the flag clears, and then restarts the settle delay in full.

Both delays are counted in clock cycles. By default they are derived from the clock frequency in kHz: about 10 ms for settle and 20 ms for soft-start. They can also be overridden directly. The mode and every control output are registered.

Top module: `pwr_mode_seq`

## Requirements
- R1: Whenever `ext_rst_n` is low or `por` is high at a clock edge, `mode` reads 0 (reset) after that edge, and `blk_pwr_en`, `boost_on`, `soft_start` and `led_gate` are low. Mode codes: 0 reset, 1 standby, 2 startup, 3 soft-start, 4 normal.
- R2: From reset with both reset sources released, the next edge moves `mode` to 1 (standby), and all enables stay low.
- R3: Standby moves to startup (2) on the first edge where `stby_rel` is high. With reset released, `stby_rel` low at an edge returns any of modes 2, 3 or 4 to standby at that edge.
- R4: In startup, `blk_pwr_en` is high. The machine stays in startup for exactly `STARTUP_CYC` edges, and stays longer while `vref_ok` is low. It leaves at the first edge where the delay is done and `vref_ok` is high.
- R5: On leaving startup, the machine goes to soft-start (3) if `boost_req` is high and to normal (4) if it is low.
- R6: Soft-start lasts exactly `SOFT_CYC` edges, with `soft_start` and `boost_on` high and `led_gate` low throughout. It then enters normal mode with `led_gate` high.
- R7: In normal mode, a rising edge of `boost_req` (low at the previous edge, high at this one) enters soft-start at that edge. A rising edge outside normal mode neither extends soft-start nor re-enters it afterwards.
- R8: `therm_flt` high at an edge in modes 2, 3 or 4 gives mode 2 with `boost_on` and `led_gate` low. Mode stays 2 while the flag is high. After the last edge with the flag high, startup lasts `STARTUP_CYC` more edges.
- R9: `boost_req` low in normal mode turns `boost_on` low at the next edge. `mode` stays 4 and `led_gate` stays high.
- R10: `reg_clr` is high for exactly one cycle on each entry to reset mode, and is held high during the system reset `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset of the sequencer flops |
| ext_rst_n | input | 1 | External active-low chip reset pin (forces reset mode) |
| por | input | 1 | Power-on-reset flag (forces reset mode) |
| stby_rel | input | 1 | Standby-release control bit |
| boost_req | input | 1 | Boost-enable control bit |
| vref_ok | input | 1 | Reference has reached 95% of its final value |
| therm_flt | input | 1 | Thermal-shutdown flag |
| mode | output | 3 | Current mode code |
| blk_pwr_en | output | 1 | Power-up enable for reference, bias and oscillator |
| boost_on | output | 1 | Boost converter enable |
| soft_start | output | 1 | Low-current soft-start PWM request |
| led_gate | output | 1 | LED outputs allowed (low blanks every LED) |
| reg_clr | output | 1 | Register-file clear pulse |

## Verification
A wrong mode register shows at once on `mode` and on the enables derived from it, one edge after the inputs that caused it. A delay counter that loads or decrements incorrectly shows as a startup or soft-start that is a cycle short or long. Measuring each timed stay edge by edge therefore catches it within one delay period. A broken edge detector shows either as a soft-start re-entered after a bit toggles inside soft-start, or as normal mode failing to react to a fresh rising edge.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the power mode sequencer.
// Assumes the mode codes below are decoded by software and must not move.
package pwr_seq_pkg;

    localparam int unsigned MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_RESET     = 3'd0,
        MD_STANDBY   = 3'd1,
        MD_STARTUP   = 3'd2,
        MD_SOFTSTART = 3'd3,
        MD_NORMAL    = 3'd4
    } pwr_mode_e;

endpackage

// File: rtl/pwr_seq_edge.sv
// Rising-edge detector for a level control bit.
// Assumes the bit is already synchronous to clk; one registered copy is kept.
module pwr_seq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic lvl_d;

    // Keep last cycle's copy of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;

endmodule

// File: rtl/pwr_seq_timer.sv
// Down-counter that times the settle and soft-start phases.
// Assumes load is given on every entry to a timed state; the load value is
// chosen from the state being entered, and zero for untimed states.
module pwr_seq_timer
    import pwr_seq_pkg::*;
#(
    parameter int unsigned STARTUP_CYC = 16,
    parameter int unsigned SOFT_CYC    = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  pwr_mode_e load_mode,
    output logic      done
);

    localparam int unsigned MAX_CYC = (STARTUP_CYC > SOFT_CYC) ? STARTUP_CYC : SOFT_CYC;
    localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] ST_LOAD = CNT_W'(STARTUP_CYC - 1);
    localparam logic [CNT_W-1:0] SS_LOAD = CNT_W'(SOFT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Pick the reload value for the state being entered.
    always_comb begin
        case (load_mode)
            MD_STARTUP:   load_val = ST_LOAD;
            MD_SOFTSTART: load_val = SS_LOAD;
            default:      load_val = '0;
        endcase
    end

    // Reload on entry, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    initial begin
        AST_DELAY_NONZERO: assert (STARTUP_CYC >= 1 && SOFT_CYC >= 1); // R4
    end

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6

endmodule

// File: rtl/pwr_seq_fsm.sv
// Mode state machine and registered control outputs.
// Assumes rst_force already merges the reset pin and the power-on flag, and
// that tmr_done comes from a timer loaded whenever tmr_load is high.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rst_force,
    input  logic      stby_rel,
    input  logic      boost_req,
    input  logic      boost_rise,
    input  logic      vref_ok,
    input  logic      therm_flt,
    input  logic      tmr_done,
    output pwr_mode_e mode_q,
    output pwr_mode_e mode_nxt,
    output logic      tmr_load,
    output logic      blk_pwr_en_q,
    output logic      boost_on_q,
    output logic      soft_start_q,
    output logic      led_gate_q,
    output logic      reg_clr_q
);

    // Next mode: reset first, then standby release, then thermal, then timers.
    always_comb begin
        mode_nxt = mode_q;
        if (rst_force) begin
            mode_nxt = MD_RESET;
        end else begin
            case (mode_q)
                MD_RESET:   mode_nxt = MD_STANDBY;
                MD_STANDBY: if (stby_rel) mode_nxt = MD_STARTUP;
                MD_STARTUP: begin
                    if (!stby_rel)                          mode_nxt = MD_STANDBY;
                    else if (!therm_flt && tmr_done && vref_ok)
                        mode_nxt = boost_req ? MD_SOFTSTART : MD_NORMAL;
                end
                MD_SOFTSTART: begin
                    if (!stby_rel)      mode_nxt = MD_STANDBY;
                    else if (therm_flt) mode_nxt = MD_STARTUP;
                    else if (tmr_done)  mode_nxt = MD_NORMAL;
                end
                MD_NORMAL: begin
                    if (!stby_rel)       mode_nxt = MD_STANDBY;
                    else if (therm_flt)  mode_nxt = MD_STARTUP;
                    else if (boost_rise) mode_nxt = MD_SOFTSTART;
                end
                default: mode_nxt = MD_RESET;
            endcase
        end
    end

    // Reload the timer on any mode change and while a thermal event holds startup.
    assign tmr_load = (mode_nxt != mode_q) ||
                      (mode_q == MD_STARTUP && therm_flt && !rst_force);

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MD_RESET;
        else        mode_q <= mode_nxt;
    end

    // Registered control outputs, decoded from the next mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_pwr_en_q <= 1'b0;
            boost_on_q   <= 1'b0;
            soft_start_q <= 1'b0;
            led_gate_q   <= 1'b0;
            reg_clr_q    <= 1'b1;
        end else begin
            blk_pwr_en_q <= (mode_nxt == MD_STARTUP) || (mode_nxt == MD_SOFTSTART) ||
                            (mode_nxt == MD_NORMAL);
            boost_on_q   <= (mode_nxt == MD_SOFTSTART) ||
                            (mode_nxt == MD_NORMAL && boost_req);
            soft_start_q <= (mode_nxt == MD_SOFTSTART);
            led_gate_q   <= (mode_nxt == MD_NORMAL);
            reg_clr_q    <= (mode_nxt == MD_RESET) && (mode_q != MD_RESET);
        end
    end

    AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_RESET && !rst_force) |=> (mode_q == MD_STANDBY)); // R2

    AST_STANDBY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_force && !stby_rel) |=> (mode_q == MD_STANDBY)); // R3

    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_STARTUP && !rst_force && stby_rel && (!tmr_done || !vref_ok))
        |=> (mode_q == MD_STARTUP)); // R4

    AST_SOFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_start_q) |-> ($past(mode_q) == MD_STARTUP || $past(mode_q) == MD_NORMAL)); // R5

    AST_LED_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        soft_start_q |-> (!led_gate_q && boost_on_q)); // R6

    AST_THERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_flt && !rst_force && stby_rel && mode_q != MD_RESET && mode_q != MD_STANDBY)
        |=> (mode_q == MD_STARTUP && !boost_on_q)); // R8

    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clr_q |=> !reg_clr_q); // R10

endmodule

// File: rtl/pwr_mode_seq.sv
// Top of the power mode sequencer: merges the reset sources, detects the
// boost-enable rising edge, times the phases and runs the mode machine.
// Assumes all inputs are synchronous to clk; delays are given in cycles.
module pwr_mode_seq
    import pwr_seq_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 100_000,
    parameter int unsigned STARTUP_CYC = CLK_KHZ * 10,
    parameter int unsigned SOFT_CYC    = CLK_KHZ * 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_n,
    input  logic              por,
    input  logic              stby_rel,
    input  logic              boost_req,
    input  logic              vref_ok,
    input  logic              therm_flt,
    output logic [MODE_W-1:0] mode,
    output logic              blk_pwr_en,
    output logic              boost_on,
    output logic              soft_start,
    output logic              led_gate,
    output logic              reg_clr
);

    logic      rst_force;
    logic      boost_rise;
    logic      tmr_load;
    logic      tmr_done;
    pwr_mode_e mode_q;
    pwr_mode_e mode_nxt;

    assign rst_force = !ext_rst_n || por;

    pwr_seq_edge u_boost_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (boost_req),
        .rise  (boost_rise)
    );

    pwr_seq_timer #(
        .STARTUP_CYC (STARTUP_CYC),
        .SOFT_CYC    (SOFT_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .load_mode (mode_nxt),
        .done      (tmr_done)
    );

    pwr_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_force    (rst_force),
        .stby_rel     (stby_rel),
        .boost_req    (boost_req),
        .boost_rise   (boost_rise),
        .vref_ok      (vref_ok),
        .therm_flt    (therm_flt),
        .tmr_done     (tmr_done),
        .mode_q       (mode_q),
        .mode_nxt     (mode_nxt),
        .tmr_load     (tmr_load),
        .blk_pwr_en_q (blk_pwr_en),
        .boost_on_q   (boost_on),
        .soft_start_q (soft_start),
        .led_gate_q   (led_gate),
        .reg_clr_q    (reg_clr)
    );

    assign mode = mode_q;

    AST_RESET_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rst_n || por) |=> (mode == 3'd0 && !blk_pwr_en && !boost_on && !led_gate)); // R1

    AST_BOOST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && ext_rst_n && !por && stby_rel && !therm_flt && !boost_req)
        |=> (mode == 3'd4 && !boost_on && led_gate)); // R9

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

    localparam int ST = 5;
    localparam int SS = 8;

    logic       clk = 1'b0;
    logic       rst_n, ext_rst_n, por, stby_rel, boost_req, vref_ok, therm_flt;
    logic [2:0] mode;
    logic       blk_pwr_en, boost_on, soft_start, led_gate, reg_clr;

    int total = 0;
    int bad   = 0;
    int wd    = 0;

    always #2 clk = ~clk;

    pwr_mode_seq #(.STARTUP_CYC(ST), .SOFT_CYC(SS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .por(por),
        .stby_rel(stby_rel), .boost_req(boost_req), .vref_ok(vref_ok),
        .therm_flt(therm_flt), .mode(mode), .blk_pwr_en(blk_pwr_en),
        .boost_on(boost_on), .soft_start(soft_start), .led_gate(led_gate),
        .reg_clr(reg_clr)
    );

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 20000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run did not finish, got=%0d expected<=%0d", wd, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Tick until mode leaves m, return number of edges taken.
    task automatic stay(input logic [2:0] m, output int n);
        n = 0;
        while (mode == m && n < 200) begin
            tick();
            n++;
        end
    endtask

    int n;

    initial begin
        rst_n = 0; ext_rst_n = 1; por = 0; stby_rel = 0;
        boost_req = 0; vref_ok = 1; therm_flt = 0;
        repeat (3) tick();
        chk("R1 mode in system reset", mode, 0);
        chk("R10 reg_clr held in system reset", reg_clr, 1);
        chk("R1 blk_pwr_en in reset", blk_pwr_en, 0);

        rst_n = 1;
        tick();
        chk("R2 reset to standby", mode, 1);
        chk("R10 reg_clr drops", reg_clr, 0);
        chk("R2 enables low in standby", {blk_pwr_en, boost_on, soft_start, led_gate}, 0);
        tick();
        chk("R3 standby holds without release", mode, 1);

        // Startup straight to normal.
        stby_rel = 1;
        tick();
        chk("R3 standby to startup", mode, 2);
        chk("R4 blk_pwr_en in startup", blk_pwr_en, 1);
        stay(3'd2, n);
        chk("R4 startup length", n, ST);
        chk("R5 boost low goes normal", mode, 4);
        chk("R6 led_gate in normal", led_gate, 1);
        chk("R9 boost off in normal", boost_on, 0);

        // Rising edge in normal enters soft-start.
        boost_req = 1;
        tick();
        chk("R7 edge in normal enters soft", mode, 3);
        chk("R6 soft_start high", soft_start, 1);
        chk("R6 led blanked in soft", led_gate, 0);
        chk("R6 boost on in soft", boost_on, 1);
        stay(3'd3, n);
        chk("R6 soft length", n, SS);
        chk("R6 soft to normal", mode, 4);
        chk("R6 led on after soft", led_gate, 1);
        chk("R9 boost stays on", boost_on, 1);

        // Drop boost in normal.
        boost_req = 0;
        tick();
        chk("R9 boost off after drop", boost_on, 0);
        chk("R9 stays normal", mode, 4);
        chk("R9 led stays on", led_gate, 1);

        // Edge inside soft-start is ignored.
        boost_req = 1;
        tick();
        chk("R7 second edge enters soft", mode, 3);
        n = 0;
        while (mode == 3 && n < 200) begin
            boost_req = (n == 2) ? 1'b0 : 1'b1;
            tick();
            n++;
        end
        chk("R7 soft not extended by inner edge", n, SS);
        repeat (3) tick();
        chk("R7 no re-entry after soft", mode, 4);

        // Thermal event from normal.
        boost_req = 0;
        therm_flt = 1;
        tick();
        chk("R8 thermal to startup", mode, 2);
        chk("R8 boost off on thermal", boost_on, 0);
        chk("R8 led off on thermal", led_gate, 0);
        repeat (ST + 3) tick();
        chk("R8 held while flag", mode, 2);
        therm_flt = 0;
        stay(3'd2, n);
        chk("R8 full delay after flag clears", n, ST);
        chk("R5 to normal after thermal", mode, 4);

        // Thermal during soft-start.
        boost_req = 1;
        tick();
        tick();
        chk("R7 soft for thermal test", mode, 3);
        therm_flt = 1;
        tick();
        chk("R8 thermal from soft", mode, 2);
        therm_flt = 0;
        stay(3'd2, n);
        chk("R8 delay after soft thermal", n, ST);
        chk("R5 boost high goes soft", mode, 3);

        // Standby return from soft, startup, normal.
        stby_rel = 0;
        tick();
        chk("R3 soft to standby", mode, 1);
        chk("R3 blk off in standby", blk_pwr_en, 0);
        vref_ok = 0;
        stby_rel = 1;
        tick();
        chk("R3 restart", mode, 2);
        repeat (ST + 4) tick();
        chk("R4 waits for vref", mode, 2);
        vref_ok = 1;
        tick();
        chk("R5 vref ok with boost high", mode, 3);
        stby_rel = 0;
        tick();
        chk("R3 soft to standby again", mode, 1);
        stby_rel = 1;
        tick();
        tick();
        stby_rel = 0;
        tick();
        chk("R3 startup to standby", mode, 1);
        stby_rel = 1;
        boost_req = 0;
        tick();
        stay(3'd2, n);
        chk("R4 startup length again", n, ST);
        stby_rel = 0;
        tick();
        chk("R3 normal to standby", mode, 1);

        // Reset sources.
        stby_rel = 1;
        tick();
        stay(3'd2, n);
        chk("R5 normal before por", mode, 4);
        por = 1;
        tick();
        chk("R1 por forces reset", mode, 0);
        chk("R10 clear pulse on por", reg_clr, 1);
        chk("R1 led off in reset", led_gate, 0);
        tick();
        chk("R10 pulse is one cycle", reg_clr, 0);
        chk("R1 reset held", mode, 0);
        por = 0;
        tick();
        chk("R2 back to standby", mode, 1);
        tick();
        chk("R3 release to startup", mode, 2);
        ext_rst_n = 0;
        tick();
        chk("R1 pin forces reset", mode, 0);
        chk("R10 clear pulse on pin", reg_clr, 1);
        chk("R1 blk off on pin reset", blk_pwr_en, 0);
        ext_rst_n = 1;
        tick();
        chk("R2 standby after pin", mode, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule